// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block holds the configuration word of a power-line modem and loads it from a host over a short synchronous serial link. The block generates the shift clock itself. While the host holds the select line high it presents one data bit per shift-clock period, most significant bit first. Each bit is captured on the rising edge of that clock. Nothing reaches the stored word until the select line falls. At that point the number of bits received decides whether the new word is committed or the write is thrown away.

The word is normally 24 bits long. Once the stored word has its extended-mode bit set, a write must carry exactly 48 bits. This makes a stray or partial write during line disturbance much less likely to change the setup. The stored word is decoded into registered outputs: carrier channel index, baud rate, tone deviation in hertz, watchdog enable, frame-header recognition and header length.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous active-high reset loads the default word 48'h000000000004. After reset the outputs show channel 4, 600 baud, deviation 300 Hz, watchdog off, extended mode off, and header recognition off.
- R2: In normal mode (word bit 21 = 0), a write of 24 or more bits stores the last 24 bits received into word bits 23:0. The first of those bits lands in bit 23.
- R3: In normal mode, a write of fewer than 24 bits leaves the whole stored word unchanged.
- R4: In extended mode (word bit 21 = 1), a write of exactly 48 bits replaces all 48 bits of the word. The first bit received lands in bit 47.
- R5: In extended mode, a write of any other length (24, 47 or 49 bits, for example) leaves the word unchanged.
- R6: The word changes only when the select line falls. The decoded outputs show the new value by the second rising clock edge after the first edge at which select is seen low. While select stays high the outputs keep their old value.
- R7: The shift clock output has a period of 2*HALF system clocks. Data is captured only on its rising edge, and only while select is high. Data toggled while select is low has no effect.
- R8: Word bits 2:0 give the channel. Bits 4:3 give the baud code, where baud = 600 shifted left by the code (600, 1200, 2400, 4800). Bit 5 gives the deviation: baud when bit 5 = 1, baud/2 when it is 0. Bit 6 is the watchdog enable.
- R9: Bit 18 (header recognition on) and bit 20 (16-bit header when 1, 8-bit when 0) drive their outputs only while bit 21 is 1. Otherwise both outputs are 0.
- R10: A committed normal-mode write leaves word bits 47:24 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register-access select from host |
| dat_i | input | 1 | Serial data from host, MSB first |
| ser_clk_o | output | 1 | Shift clock generated by the block |
| cfg_word_o | output | 48 | Stored configuration word |
| chan_o | output | 3 | Carrier channel index |
| baud_sel_o | output | 2 | Baud rate code |
| baud_hz_o | output | 13 | Baud rate in symbols per second |
| dev_hz_o | output | 13 | Tone deviation in hertz |
| dev_full_o | output | 1 | Deviation equals baud rate |
| wdog_en_o | output | 1 | Watchdog enable |
| hdr_en_o | output | 1 | Frame-header recognition enabled |
| hdr16_o | output | 1 | Header length is 16 bits |
| ext_o | output | 1 | Extended 48-bit mode active |

## Verification
The hardest case is extended mode, where the commit hinges on the count being exactly 48. Reaching it takes a normal-mode write that sets bit 21. Writes of 24, 47 and 49 bits must then fail before a 48-bit write succeeds. A final 48-bit write clears bit 21 again, and the stimulus then confirms that a later short-form write keeps the upper half intact. Over-length writes in normal mode put the most recent bits in a distinctive pattern, so a design that keeps the first bits instead of the last is caught.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  // Field positions inside the configuration word
  localparam int CH_LSB      = 0;
  localparam int CH_W        = 3;
  localparam int BAUD_LSB    = 3;
  localparam int BAUD_W      = 2;
  localparam int DEV_BIT     = 5;
  localparam int WDOG_BIT    = 6;
  localparam int HDR_EN_BIT  = 18;
  localparam int HDR_LEN_BIT = 20;
  localparam int EXT_BIT     = 21;
  // Rate arithmetic
  localparam int BHZ_W       = 13;
  localparam int BASE_BAUD   = 600;
endpackage

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sclk_o,
  output logic rise_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = wrap & ~sclk_q;

  // The capture strobe and the visible clock edge coincide
  assert_rise_sets_clk_R7: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> sclk_o);
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(sclk_o));
endmodule

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
  parameter int W  = 48,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          dat_i,
  input  logic          rise_i,
  output logic [W-1:0]  sh_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!sel_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q <= {sh_q[W-2:0], dat_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sh_o  = sh_q;
  assign cnt_o = cnt_q;

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> (cnt_o == '0));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i && rise_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_no_shift_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!rise_i || !sel_i) |=> $stable(sh_o));
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfg_pkg::*;
#(
  parameter int              NRM_W    = 24,
  parameter int              EXT_W    = 48,
  parameter int              CW       = 7,
  parameter logic [EXT_W-1:0] DEF_WORD = 48'h4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [EXT_W-1:0] sh_i,
  output logic [EXT_W-1:0] word_o
);
  logic [EXT_W-1:0] word_q;
  logic             sel_q;
  logic             fall;
  logic             ext;
  logic             nrm_ok;
  logic             ext_ok;

  assign fall   = sel_q & ~sel_i;
  assign ext    = word_q[EXT_BIT];
  assign nrm_ok = (cnt_i >= CW'(NRM_W));
  assign ext_ok = (cnt_i == CW'(EXT_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      word_q <= DEF_WORD;
    end else begin
      sel_q <= sel_i;
      if (fall) begin
        if (ext) begin
          if (ext_ok) word_q <= sh_i;
        end else if (nrm_ok) begin
          word_q[NRM_W-1:0] <= sh_i[NRM_W-1:0];
        end
      end
    end
  end

  assign word_o = word_q;

  assert_only_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(word_o));
  assert_short_abort_R3: assert property (@(posedge clk) disable iff (rst)
    (fall && !ext && cnt_i < CW'(NRM_W)) |=> $stable(word_o));
  assert_normal_load_R2: assert property (@(posedge clk) disable iff (rst)
    (fall && !ext && cnt_i >= CW'(NRM_W)) |=> (word_o[NRM_W-1:0] == $past(sh_i[NRM_W-1:0])));
  assert_upper_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (fall && !ext) |=> (word_o[EXT_W-1:NRM_W] == $past(word_o[EXT_W-1:NRM_W])));
  assert_ext_load_R4: assert property (@(posedge clk) disable iff (rst)
    (fall && ext && cnt_i == CW'(EXT_W)) |=> (word_o == $past(sh_i)));
  assert_ext_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (fall && ext && cnt_i != CW'(EXT_W)) |=> $stable(word_o));
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_pkg::*;
#(
  parameter int              EXT_W    = 48,
  parameter logic [EXT_W-1:0] DEF_WORD = 48'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXT_W-1:0]  word_i,
  output logic [EXT_W-1:0]  word_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [BAUD_W-1:0] baud_sel_o,
  output logic [BHZ_W-1:0]  baud_hz_o,
  output logic [BHZ_W-1:0]  dev_hz_o,
  output logic              dev_full_o,
  output logic              wdog_en_o,
  output logic              hdr_en_o,
  output logic              hdr16_o,
  output logic              ext_o
);
  logic [EXT_W-1:0]  src;
  logic [BAUD_W-1:0] bsel;
  logic [BHZ_W-1:0]  bhz;

  assign src  = rst ? DEF_WORD : word_i;
  assign bsel = src[BAUD_LSB +: BAUD_W];
  assign bhz  = BHZ_W'(BASE_BAUD) << bsel;

  always_ff @(posedge clk) begin
    word_o     <= src;
    chan_o     <= src[CH_LSB +: CH_W];
    baud_sel_o <= bsel;
    baud_hz_o  <= bhz;
    dev_full_o <= src[DEV_BIT];
    dev_hz_o   <= src[DEV_BIT] ? bhz : (bhz >> 1);
    wdog_en_o  <= src[WDOG_BIT];
    ext_o      <= src[EXT_BIT];
    hdr_en_o   <= src[HDR_EN_BIT] & src[EXT_BIT];
    hdr16_o    <= src[HDR_LEN_BIT] & src[EXT_BIT];
  end

  assert_hdr_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (hdr_en_o || hdr16_o) |-> ext_o);
  assert_dev_range_R8: assert property (@(posedge clk) disable iff (rst)
    (dev_hz_o == baud_hz_o) || (dev_hz_o == (baud_hz_o >> 1)));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_pkg::*;
#(
  parameter int              NRM_W    = 24,
  parameter int              EXT_W    = 48,
  parameter int              HALF     = 4,
  parameter logic [EXT_W-1:0] DEF_WORD = 48'h000000000004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              dat_i,
  output logic              ser_clk_o,
  output logic [EXT_W-1:0]  cfg_word_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [BAUD_W-1:0] baud_sel_o,
  output logic [BHZ_W-1:0]  baud_hz_o,
  output logic [BHZ_W-1:0]  dev_hz_o,
  output logic              dev_full_o,
  output logic              wdog_en_o,
  output logic              hdr_en_o,
  output logic              hdr16_o,
  output logic              ext_o
);
  localparam int CW = $clog2(EXT_W + 1) + 1;

  logic             rise;
  logic [EXT_W-1:0] sh;
  logic [CW-1:0]    cnt;
  logic [EXT_W-1:0] word;

  cfg_sclk_gen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst(rst), .sclk_o(ser_clk_o), .rise_o(rise)
  );

  cfg_shift_in #(.W(EXT_W), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .sel_i(sel_i), .dat_i(dat_i), .rise_i(rise),
    .sh_o(sh), .cnt_o(cnt)
  );

  cfg_commit #(.NRM_W(NRM_W), .EXT_W(EXT_W), .CW(CW), .DEF_WORD(DEF_WORD)) u_commit (
    .clk(clk), .rst(rst), .sel_i(sel_i), .cnt_i(cnt), .sh_i(sh), .word_o(word)
  );

  cfg_decode #(.EXT_W(EXT_W), .DEF_WORD(DEF_WORD)) u_dec (
    .clk(clk), .rst(rst), .word_i(word), .word_o(cfg_word_o),
    .chan_o(chan_o), .baud_sel_o(baud_sel_o), .baud_hz_o(baud_hz_o),
    .dev_hz_o(dev_hz_o), .dev_full_o(dev_full_o), .wdog_en_o(wdog_en_o),
    .hdr_en_o(hdr_en_o), .hdr16_o(hdr16_o), .ext_o(ext_o)
  );

  // Decoded outputs trail the stored word by one register
  assert_out_follows_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_word_o == $past(word)));
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_i = 1'b0;
  logic        dat_i = 1'b0;
  logic        ser_clk_o;
  logic [47:0] cfg_word_o;
  logic [2:0]  chan_o;
  logic [1:0]  baud_sel_o;
  logic [12:0] baud_hz_o, dev_hz_o;
  logic        dev_full_o, wdog_en_o, hdr_en_o, hdr16_o, ext_o;

  int total = 0;
  int bad   = 0;
  logic [47:0] model = 48'h4;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;
  bit          done = 0;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(.HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel_i), .dat_i(dat_i), .ser_clk_o(ser_clk_o),
    .cfg_word_o(cfg_word_o), .chan_o(chan_o), .baud_sel_o(baud_sel_o),
    .baud_hz_o(baud_hz_o), .dev_hz_o(dev_hz_o), .dev_full_o(dev_full_o),
    .wdog_en_o(wdog_en_o), .hdr_en_o(hdr_en_o), .hdr16_o(hdr16_o), .ext_o(ext_o)
  );

  function automatic logic [79:0] expect_outs(input logic [47:0] w);
    logic [12:0] b, d;
    logic        x;
    b = 13'd600 << w[4:3];
    d = w[5] ? b : (b >> 1);
    x = w[21];
    return {w, w[2:0], w[4:3], b, d, w[5], w[6], w[18] & x, w[20] & x, x};
  endfunction

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [47:0] w;
        logic [79:0] act, exp_v;
        string t;
        w = exp_q.pop_front();
        t = tag_q.pop_front();
        exp_v = expect_outs(w);
        act = {cfg_word_o, chan_o, baud_sel_o, baud_hz_o, dev_hz_o,
               dev_full_o, wdog_en_o, hdr_en_o, hdr16_o, ext_o};
        total++;
        if (act !== exp_v) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, act, exp_v);
        end
      end
    end
  end

  task automatic push_check(input string t);
    exp_q.push_back(model);
    tag_q.push_back(t);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    while (ser_clk_o) @(negedge clk);
    dat_i = b;
    @(posedge ser_clk_o);
    @(negedge clk);
  endtask

  // Driver: shifts n bits of v MSB first, updates the model, queues a check
  task automatic wr(input logic [63:0] v, input int n, input string t);
    @(negedge clk);
    sel_i = 1'b1;
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    @(negedge clk);
    sel_i = 1'b0;
    if (!model[21] && n >= 24) model[23:0] = v[23:0];
    else if (model[21] && n == 48) model = v[47:0];
    repeat (4) @(negedge clk);
    push_check(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    push_check("R1 reset default");

    wr(64'h75, 24, "R2 R8 24-bit write");
    wr(64'hABCDE, 20, "R3 20-bit abort");
    wr(64'h3F01000A, 30, "R2 30-bit keeps last 24");
    wr(64'h14001B, 24, "R9 header bits ignored in normal mode");

    // R7: data toggling with select low is ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dat_i = i[0];
      @(posedge ser_clk_o);
    end
    repeat (4) @(negedge clk);
    push_check("R7 idle toggles ignored");

    // R6: outputs hold while select stays high after a full word
    @(negedge clk);
    sel_i = 1'b1;
    for (int i = 23; i >= 0; i--) send_bit(i < 3);
    repeat (4) @(negedge clk);
    push_check("R6 no change before select falls");
    sel_i = 1'b0;
    model[23:0] = 24'h7;
    repeat (4) @(negedge clk);
    push_check("R6 change after select falls");

    // R7: shift clock period
    begin
      int c;
      c = 0;
      @(posedge ser_clk_o);
      @(negedge clk);
      while (!ser_clk_o) begin c++; @(negedge clk); end
      while (ser_clk_o) begin c++; @(negedge clk); end
      while (!ser_clk_o) begin c++; @(negedge clk); end
      total++;
      if (c != 2 * HALF) begin
        bad++;
        $display("FAIL R7 period actual=%0d expected=%0d", c, 2 * HALF);
      end
    end

    wr(64'h200003, 24, "R4 enter extended mode");
    wr(64'h1, 24, "R5 24-bit abort in extended");
    wr(64'h7FFF_FFFF_FFFF, 47, "R5 47-bit abort");
    wr(64'h1_5555_5555_5555, 49, "R5 49-bit abort");
    wr(64'hA5A5C3_34001C, 48, "R4 R9 48-bit commit");
    wr(64'h123456_000009, 48, "R4 48-bit leaves extended");
    wr(64'h0000C, 24, "R10 upper half kept");

    @(negedge clk);
    rst = 1'b1;
    model = 48'h4;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    push_check("R1 reset again");

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule